// File: doc/BRIEF.md
# Bit-Oriented Frame Serializer

This block turns a stream of octets into a synchronous serial bit stream framed for a bit-oriented link. A frame on the line begins with opening flags (the octet 01111110), carries the caller's octets (an address of two to four octets followed by any number of information octets), closes with a 16-bit or 32-bit frame check sequence, and ends with a flag. When no frame is waiting, the line carries unbroken flags.

Octets enter one at a time through a valid/ready pair. Each octet carries a start marker and an end marker. A one-octet holding register decouples the byte side from the bit side. The bit side advances once per `bit_en_i` strobe. Each emitted bit appears on `tx_o` together with a one-cycle `tx_en_o` pulse. The transparency rule inserts a zero after five consecutive ones anywhere between flags. The number of opening flags is set by `cfg_flags_i`. When frames follow each other closely, the closing flag of one frame counts as the first opening flag of the next, so a setting of one gives a single shared flag.

Top module: `hdlc_tx`

## Requirements
- R1: After reset, and whenever no frame is pending, `tx_o` carries back-to-back flags 01111110. The first emitted bit after reset is the first bit of a flag. During reset `tx_o` is 1.
- R2: Every octet of a frame is sent once, in arrival order, least significant bit first. After zero deletion, the count of octets between flags equals the octet count supplied plus the FCS octets.
- R3: With the FCS size set to 16, the last two octets carry the one's complement of a CRC with the reflected CCITT polynomial 0x8408 (x^16+x^12+x^5+1), preset to all ones, computed over all octets LSB first and sent LSB first.
- R4: With the FCS size set to 32, the last four octets carry the complement of a CRC with the reflected polynomial 0xEDB88320, preset to all ones, sent LSB first.
- R5: After any five consecutive ones in the octet or FCS fields, a zero is inserted, including just before the closing flag. Flags are never altered.
- R6: A frame that becomes pending while the line is idle is preceded by the flag in progress plus `cfg_flags_i` further flags, where 0 counts as 1. At least N+1 flags therefore precede it.
- R7: A frame whose start octet is waiting when the previous closing flag ends is separated from that frame by exactly max(N,1) flags, the closing flag included.
- R8: Every frame's FCS is followed by a flag.
- R9: `tx_en_o` is high exactly in the cycle after each cycle in which `bit_en_i` is high. `tx_o` changes only at those edges.
- R10: `byte_ready_o` is high exactly when the holding register is empty. It is high after reset, and it is low in the cycle after an octet is accepted.
- R11: The FCS size is sampled when a frame's first octet is loaded. A change of `cfg_fcs32_i` later in the frame does not change that frame's FCS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-slot strobe, one output bit per pulse |
| byte_valid_i | input | 1 | Octet offered |
| byte_data_i | input | 8 | Octet value |
| byte_sof_i | input | 1 | Octet is the first of a frame |
| byte_eof_i | input | 1 | Octet is the last of a frame |
| byte_ready_o | output | 1 | Holding register empty, octet will be taken |
| cfg_flags_i | input | FLAGS_W (4) | Opening flag count N (0 treated as 1) |
| cfg_fcs32_i | input | 1 | 1 selects 32-bit FCS, 0 selects 16-bit |
| tx_o | output | 1 | Serial line bit |
| tx_en_o | output | 1 | Pulses in the cycle `tx_o` holds a new bit |

## Verification
The bench decodes the line like a receiver: it finds flags, deletes stuffed zeros, and recovers each frame. It then compares the octets, the FCS and the count of deleted zeros against its own CRC and stuffing models. A design that skipped the zero before a closing flag would lose the frame or corrupt its end. A design that fed the CRC one bit short would fail the FCS compare.

Frames of all-ones octets and random streams that favour 0xFF stress the run counter. A flag-count setting of 0, 1 and larger values, applied to back-to-back frames, exposes an off-by-one in the shared-flag rule as a wrong flag count. A mid-frame toggle of the FCS size catches a design that reads the size live instead of latching it.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [1:0] {
    ST_FLAG = 2'd0,
    ST_DATA = 2'd1,
    ST_FCS  = 2'd2
  } tx_state_e;

  localparam logic [7:0]  FLAG_PAT   = 8'h7E;
  localparam logic [15:0] CRC16_POLY = 16'h8408;
  localparam logic [31:0] CRC32_POLY = 32'hEDB88320;
  localparam int          STUFF_RUN  = 5;
endpackage

// File: rtl/hdlc_crc.sv
module hdlc_crc #(
  parameter int            WIDTH = 16,
  parameter logic [31:0]   POLY  = 32'h8408
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             step_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] crc_d_o
);
  localparam logic [WIDTH-1:0] POLY_W = POLY[WIDTH-1:0];

  logic [WIDTH-1:0] crc_q, crc_d;
  logic             fb;

  assign fb = crc_q[0] ^ bit_i;

  always_comb begin
    crc_d = crc_q;
    if (init_i)      crc_d = '1;
    else if (step_i) crc_d = (crc_q >> 1) ^ (fb ? POLY_W : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '1;
    else         crc_q <= crc_d;
  end

  // next value so the final data bit is included when the FCS is loaded
  assign crc_d_o = crc_d;

  // R3
  crc_preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> crc_q == '1);
endmodule

// File: rtl/hdlc_stuffer.sv
module hdlc_stuffer
  import hdlc_tx_pkg::*;
#(
  parameter int RUN = STUFF_RUN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic raw_bit_i,
  input  logic raw_stuff_i,
  output logic adv_o,
  output logic tx_o,
  output logic tx_en_o
);
  localparam int OW = $clog2(RUN + 1);

  logic [OW-1:0] ones_q;
  logic          insert;
  logic          tx_q, tx_en_q;

  assign insert = (ones_q == OW'(RUN));
  assign adv_o  = bit_en_i && !insert;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q  <= '0;
      tx_q    <= 1'b1;
      tx_en_q <= 1'b0;
    end else begin
      tx_en_q <= bit_en_i;
      if (bit_en_i) begin
        if (insert) begin
          tx_q   <= 1'b0;
          ones_q <= '0;
        end else begin
          tx_q   <= raw_bit_i;
          ones_q <= (raw_stuff_i && raw_bit_i) ? ones_q + OW'(1) : '0;
        end
      end
    end
  end

  assign tx_o    = tx_q;
  assign tx_en_o = tx_en_q;

  // R5
  stuff_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && ones_q == OW'(RUN)) |=> !tx_o);
  // R9
  en_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i |=> tx_en_o);
  // R9
  line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> (!tx_en_o && $stable(tx_o)));
endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int FLAGS_W  = 4,
  parameter bit FCS32_EN = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  input  logic               hold_v_i,
  input  logic [7:0]         hold_data_i,
  input  logic               hold_sof_i,
  input  logic               hold_eof_i,
  input  logic [FLAGS_W-1:0] cfg_flags_i,
  input  logic               cfg_fcs32_i,
  input  logic [15:0]        crc16_i,
  input  logic [31:0]        crc32_i,
  output logic               hold_take_o,
  output logic               raw_bit_o,
  output logic               raw_stuff_o,
  output logic               crc_init_o,
  output logic               crc_step_o,
  output logic               crc_bit_o
);
  localparam int CNT_W = 5;

  tx_state_e          st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [31:0]        sh_q;
  logic [FLAGS_W-1:0] rem_q;
  logic               armed_q, closing_q, last_q, fcs32_q;

  logic [FLAGS_W-1:0] n_eff;
  logic [CNT_W-1:0]   fcs_last;
  logic               pend, unit_last, flag_end, data_end, go_data, discard;
  logic [31:0]        fcs_val;

  assign n_eff     = (cfg_flags_i == '0) ? FLAGS_W'(1) : cfg_flags_i;
  assign pend      = hold_v_i && hold_sof_i;
  assign fcs_last  = fcs32_q ? CNT_W'(31) : CNT_W'(15);
  assign unit_last = (st_q == ST_FCS) ? (cnt_q == fcs_last) : (cnt_q == CNT_W'(7));
  assign flag_end  = adv_i && (st_q == ST_FLAG) && unit_last;
  assign data_end  = adv_i && (st_q == ST_DATA) && unit_last;
  // closing flag doubles as first opening flag when N is one
  assign go_data   = pend && (armed_q ? (rem_q == '0) : (closing_q && n_eff == FLAGS_W'(1)));
  assign discard   = !armed_q && !go_data && hold_v_i && !hold_sof_i;
  assign fcs_val   = (FCS32_EN && fcs32_q) ? ~crc32_i : {16'h0, ~crc16_i};

  assign hold_take_o = (flag_end && (go_data || discard)) ||
                       (data_end && !last_q && hold_v_i);
  assign raw_bit_o   = (st_q == ST_FLAG) ? FLAG_PAT[cnt_q[2:0]] : sh_q[0];
  assign raw_stuff_o = (st_q != ST_FLAG);
  assign crc_init_o  = flag_end && go_data;
  assign crc_step_o  = adv_i && (st_q == ST_DATA);
  assign crc_bit_o   = sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_FLAG;
      cnt_q     <= '0;
      sh_q      <= '0;
      rem_q     <= '0;
      armed_q   <= 1'b0;
      closing_q <= 1'b0;
      last_q    <= 1'b0;
      fcs32_q   <= 1'b0;
    end else if (adv_i) begin
      if (!unit_last) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (st_q != ST_FLAG) sh_q <= sh_q >> 1;
      end else begin
        cnt_q <= '0;
        case (st_q)
          ST_FLAG: begin
            closing_q <= 1'b0;
            if (go_data) begin
              st_q    <= ST_DATA;
              sh_q    <= {24'h0, hold_data_i};
              last_q  <= hold_eof_i;
              fcs32_q <= cfg_fcs32_i & FCS32_EN;
              armed_q <= 1'b0;
            end else if (armed_q) begin
              rem_q <= rem_q - FLAGS_W'(1);
            end else if (pend) begin
              armed_q <= 1'b1;
              rem_q   <= closing_q ? n_eff - FLAGS_W'(2) : n_eff - FLAGS_W'(1);
            end
          end
          ST_DATA: begin
            if (last_q || !hold_v_i) begin
              st_q <= ST_FCS;
              sh_q <= fcs_val;
            end else begin
              sh_q   <= {24'h0, hold_data_i};
              last_q <= hold_eof_i;
            end
          end
          ST_FCS: begin
            st_q      <= ST_FLAG;
            closing_q <= 1'b1;
          end
          default: st_q <= ST_FLAG;
        endcase
      end
    end
  end

  // R8
  fcs_then_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && st_q == ST_FCS && unit_last) |=> (st_q == ST_FLAG && closing_q));
  // R11
  fcs_size_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_FLAG && $past(st_q) != ST_FLAG) |-> $stable(fcs32_q));
  // R6
  data_after_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == ST_DATA) |-> $past(st_q == ST_FLAG));
endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
  import hdlc_tx_pkg::*;
#(
  parameter int FLAGS_W  = 4,
  parameter bit FCS32_EN = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_en_i,
  input  logic               byte_valid_i,
  input  logic [7:0]         byte_data_i,
  input  logic               byte_sof_i,
  input  logic               byte_eof_i,
  output logic               byte_ready_o,
  input  logic [FLAGS_W-1:0] cfg_flags_i,
  input  logic               cfg_fcs32_i,
  output logic               tx_o,
  output logic               tx_en_o
);
  logic       hold_v_q, hold_sof_q, hold_eof_q;
  logic [7:0] hold_data_q;
  logic       take, adv, raw_bit, raw_stuff;
  logic       crc_init, crc_step, crc_bit;
  logic [15:0] crc16_d;
  logic [31:0] crc32_d;

  assign byte_ready_o = !hold_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q    <= 1'b0;
      hold_sof_q  <= 1'b0;
      hold_eof_q  <= 1'b0;
      hold_data_q <= '0;
    end else if (take) begin
      hold_v_q <= 1'b0;
    end else if (byte_valid_i && !hold_v_q) begin
      hold_v_q    <= 1'b1;
      hold_sof_q  <= byte_sof_i;
      hold_eof_q  <= byte_eof_i;
      hold_data_q <= byte_data_i;
    end
  end

  hdlc_tx_ctrl #(.FLAGS_W(FLAGS_W), .FCS32_EN(FCS32_EN)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (adv),
    .hold_v_i    (hold_v_q),
    .hold_data_i (hold_data_q),
    .hold_sof_i  (hold_sof_q),
    .hold_eof_i  (hold_eof_q),
    .cfg_flags_i (cfg_flags_i),
    .cfg_fcs32_i (cfg_fcs32_i),
    .crc16_i     (crc16_d),
    .crc32_i     (crc32_d),
    .hold_take_o (take),
    .raw_bit_o   (raw_bit),
    .raw_stuff_o (raw_stuff),
    .crc_init_o  (crc_init),
    .crc_step_o  (crc_step),
    .crc_bit_o   (crc_bit)
  );

  hdlc_crc #(.WIDTH(16), .POLY({16'h0, CRC16_POLY})) u_crc16 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (crc_init),
    .step_i  (crc_step),
    .bit_i   (crc_bit),
    .crc_d_o (crc16_d)
  );

  generate
    if (FCS32_EN) begin : g_crc32
      hdlc_crc #(.WIDTH(32), .POLY(CRC32_POLY)) u_crc32 (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .init_i  (crc_init),
        .step_i  (crc_step),
        .bit_i   (crc_bit),
        .crc_d_o (crc32_d)
      );
    end else begin : g_no_crc32
      assign crc32_d = '1;
    end
  endgenerate

  hdlc_stuffer #(.RUN(STUFF_RUN)) u_stuff (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_en_i    (bit_en_i),
    .raw_bit_i   (raw_bit),
    .raw_stuff_i (raw_stuff),
    .adv_o       (adv),
    .tx_o        (tx_o),
    .tx_en_o     (tx_en_o)
  );

  // R10
  take_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && byte_ready_o) |=> !byte_ready_o);
  // R10
  no_take_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |-> hold_v_q);
endmodule

// File: tb/tb_hdlc_tx.sv
module tb_hdlc_tx;
  localparam int FW   = 4;
  localparam int NF   = 34;
  localparam int MAXB = 16;
  localparam int DB   = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_en = 1'b0;
  logic          bv = 1'b0;
  logic [7:0]    bd = '0;
  logic          bs = 1'b0, be = 1'b0;
  logic          ready;
  logic [FW-1:0] cfg_n = FW'(1);
  logic          cfg32 = 1'b0;
  logic          tx, tx_en;

  always #10 clk = ~clk;

  hdlc_tx #(.FLAGS_W(FW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en),
    .byte_valid_i(bv), .byte_data_i(bd), .byte_sof_i(bs), .byte_eof_i(be),
    .byte_ready_o(ready), .cfg_flags_i(cfg_n), .cfg_fcs32_i(cfg32),
    .tx_o(tx), .tx_en_o(tx_en)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0] exp_data [NF][MAXB];
  int         exp_len [NF];
  bit         exp_32 [NF];
  int         exp_n [NF];
  bit         exp_b2b [NF];
  bit         exp_flip [NF];
  int         n_sent = 0, rx_idx = 0;

  logic [7:0] h8 = '0;
  int  ones_run = 0, dlen = 0, stuffed = 0, flag_cnt = 0, bits_seen = 0;
  bit  dbits [DB];
  int  r9_bad = 0;
  bit  mon_on = 1'b0;
  logic tx_last = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] calc_fcs(int k);
    logic [31:0] c;
    c = exp_32[k] ? 32'hFFFFFFFF : 32'h0000FFFF;
    for (int i = 0; i < exp_len[k]; i++)
      for (int j = 0; j < 8; j++) begin
        if (exp_32[k]) c = (c >> 1) ^ (((c[0] ^ exp_data[k][i][j]) != 1'b0) ? 32'hEDB88320 : 32'h0);
        else           c = (c >> 1) ^ (((c[0] ^ exp_data[k][i][j]) != 1'b0) ? 32'h00008408 : 32'h0);
      end
    return exp_32[k] ? ~c : {16'h0, ~c[15:0]};
  endfunction

  function automatic int calc_stuff(int k);
    int run = 0, cnt = 0, nf;
    logic [31:0] f;
    f  = calc_fcs(k);
    nf = exp_32[k] ? 32 : 16;
    for (int i = 0; i < exp_len[k] * 8 + nf; i++) begin
      bit b;
      b = (i < exp_len[k] * 8) ? exp_data[k][i / 8][i % 8] : f[i - exp_len[k] * 8];
      if (b) begin
        run++;
        if (run == 5) begin cnt++; run = 0; end
      end else run = 0;
    end
    return cnt;
  endfunction

  task automatic check_frame(input int nbits);
    int k, fb, nexp, mism, neff;
    logic [7:0] ab, eb;
    logic [31:0] rf, ef;
    string freq;
    k = rx_idx;
    if (k >= n_sent) begin
      chk(1'b0, "R2", "unexpected frame", nbits, 0);
      return;
    end
    fb   = exp_32[k] ? 4 : 2;
    nexp = 8 * (exp_len[k] + fb);
    chk(nbits == nexp, "R2", "frame bit count", nbits, nexp);
    if (nbits == nexp) begin
      mism = 0; ab = '0; eb = '0;
      for (int i = 0; i < exp_len[k]; i++) begin
        logic [7:0] b;
        for (int j = 0; j < 8; j++) b[j] = dbits[8 * i + j];
        if (b != exp_data[k][i] && mism == 0) begin ab = b; eb = exp_data[k][i]; end
        if (b != exp_data[k][i]) mism++;
      end
      chk(mism == 0, "R2", "octet content", ab, eb);
      rf = '0;
      for (int j = 0; j < 8 * fb; j++) rf[j] = dbits[8 * exp_len[k] + j];
      ef   = calc_fcs(k);
      freq = exp_flip[k] ? "R11" : (exp_32[k] ? "R4" : "R3");
      chk(rf == ef, freq, "frame check sequence", rf, ef);
    end
    chk(stuffed == calc_stuff(k), "R5", "inserted zero count", stuffed, calc_stuff(k));
    neff = (exp_n[k] == 0) ? 1 : exp_n[k];
    if (exp_b2b[k]) chk(flag_cnt == neff, "R7", "flags between frames", flag_cnt, neff);
    else            chk(flag_cnt >= neff + 1, "R6", "flags before idle start", flag_cnt, neff + 1);
    rx_idx++;
  endtask

  task automatic rx_bit(input logic b);
    h8 = {h8[6:0], b};
    bits_seen++;
    if (ones_run == 5 && b == 1'b0) begin
      stuffed++;
      ones_run = 0;
    end else begin
      if (dlen < DB) dbits[dlen] = b;
      dlen++;
      ones_run = b ? ones_run + 1 : 0;
    end
    if (bits_seen == 8) chk(h8 == 8'h7E, "R1", "first octet after reset", h8, 8'h7E);
    if (h8 == 8'h7E && bits_seen >= 8) begin
      if (dlen - 8 == 0) flag_cnt++;
      else begin
        check_frame(dlen - 8);
        flag_cnt = 1;
      end
      dlen = 0; stuffed = 0; ones_run = 0;
    end else if (dlen >= DB) begin
      chk(1'b0, "R8", "no closing flag", dlen, 0);
      dlen = 0; stuffed = 0;
    end
  endtask

  // bit strobe every fourth cycle, line monitor on the same edge
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (tx_en !== bit_en) r9_bad++;
        if (!tx_en && tx !== tx_last) r9_bad++;
        if (tx_en) rx_bit(tx);
      end
      tx_last = tx;
      bit_en  = rst_n && (cyc % 4 == 3);
      cyc++;
    end
  end

  task automatic send_frame(input int k);
    for (int i = 0; i < exp_len[k]; i++) begin
      @(negedge clk);
      while (!ready) @(negedge clk);
      if (i == 0) begin
        cfg_n = FW'(exp_n[k]);
        cfg32 = exp_32[k];
      end
      bv = 1'b1; bd = exp_data[k][i];
      bs = (i == 0); be = (i == exp_len[k] - 1);
      @(negedge clk);
      bv = 1'b0; bs = 1'b0; be = 1'b0;
      chk(!ready, "R10", "ready after accept", ready, 0);
      if (exp_flip[k] && i == 1) cfg32 = ~cfg32;
    end
  endtask

  task automatic add_frame(input int len, input int n, input bit f32,
                           input bit b2b, input bit flip, input logic [7:0] fill);
    int k;
    k = n_sent;
    exp_len[k] = len; exp_n[k] = n; exp_32[k] = f32;
    exp_b2b[k] = b2b; exp_flip[k] = flip;
    for (int i = 0; i < len; i++)
      exp_data[k][i] = (fill == 8'h00) ? ((($urandom % 4) == 0) ? 8'hFF : 8'($urandom)) : fill;
    n_sent++;
    send_frame(k);
  endtask

  task automatic wait_drain();
    while (rx_idx < n_sent) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  initial begin
    int f0, r0;
    void'($urandom(32'd24681357));
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R10", "ready in reset", ready, 1);
    chk(tx_en == 1'b0, "R9", "strobe in reset", tx_en, 0);
    chk(tx == 1'b1, "R1", "line in reset", tx, 1);
    rst_n  = 1'b1;
    mon_on = 1'b1;
    repeat (100) @(negedge clk);

    // directed: short frame, all-ones, shared flag, N=0, long leading run
    add_frame(2, 2, 1'b0, 1'b0, 1'b0, 8'h7E);
    add_frame(6, 1, 1'b1, 1'b1, 1'b0, 8'hFF);
    add_frame(3, 0, 1'b0, 1'b1, 1'b0, 8'hFF);
    add_frame(4, 3, 1'b1, 1'b1, 1'b1, 8'h00);
    add_frame(5, 5, 1'b0, 1'b1, 1'b1, 8'h00);
    wait_drain();

    // R1: idle line carries only flags
    f0 = flag_cnt; r0 = rx_idx;
    repeat (400) @(negedge clk);
    chk(flag_cnt - f0 >= 11, "R1", "idle flags", flag_cnt - f0, 11);
    chk(rx_idx == r0, "R1", "no frame while idle", rx_idx, r0);

    // random frames in bursts
    while (n_sent < NF) begin
      bit gap;
      gap = (($urandom % 4) == 0);
      if (gap) wait_drain();
      add_frame(2 + int'($urandom % 13), int'($urandom % 5), 1'($urandom % 2),
                !gap, (($urandom % 6) == 0), 8'h00);
    end
    wait_drain();

    chk(rx_idx == n_sent, "R8", "frames closed by flag", rx_idx, n_sent);
    chk(r9_bad == 0, "R9", "strobe and line timing", r9_bad, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R8 watchdog: actual %0d expected %0d frames", rx_idx, n_sent);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule